// File: doc/BRIEF.md
# Next-PC Sequencer with Register-Tested Branches

This block holds the program counter of a word-addressed processor whose instructions are all one word long. For each executed instruction it receives a decoded control-flow kind, the 22-bit address field of the instruction, the 5-bit register field and the value read from that register. On the clock edge it loads the following PC. It also produces the link value and link write request that a subroutine call needs.

Conditional branches do not test flags. They test whether the named general register is zero. A return loads the PC from the register named in the instruction. A trap whose register field holds code 0 stops the machine. The PC then stays frozen until reset. Fetch, the register file and any pipelining sit outside the block. The decoder drives `kind`, and `step` marks a cycle in which an instruction executes.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `pc` is 0 (parameter RESET_PC), `halted` is 0 and `link_we` is 0.
- R2: The kind encoding on `kind` is 0 sequential, 1 jump, 2 jump-if-true, 3 jump-if-false, 4 call, 5 return, 6 trap, 7 reserved. A step of kind 0 or 7 loads `pc+1` at the next clock edge.
- R3: A step of kind 1 loads the 22-bit `addr_field` into `pc`, sign-extended to 32 bits (bit 21 copied into bits 31..22).
- R4: A step of kind 2 loads the sign-extended address when `reg_val` is nonzero and `pc+1` otherwise.
- R5: A step of kind 3 loads the sign-extended address when `reg_val` is zero and `pc+1` otherwise.
- R6: During a step of kind 4, the block drives `link_val = pc+1` and `link_idx = reg_sel`. It asserts `link_we` in the same cycle, and the PC then loads the sign-extended address.
- R7: A call whose `reg_sel` is 0 still jumps, but `link_we` stays 0.
- R8: A step of kind 5 loads `reg_val` into `pc`.
- R9: A step of kind 6 with `reg_sel` 0 sets `halted` at the next edge and leaves `pc` unchanged. A kind-6 step with any other code acts as a sequential step and does not halt.
- R10: While `halted` is 1, `pc` and `halted` hold and `link_we` stays 0 whatever the inputs, until reset.
- R11: While `step` is 0, `pc` holds and `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction executes this cycle |
| kind | input | 3 | Decoded control-flow kind (encoding in R2) |
| addr_field | input | 22 | Address field of the instruction |
| reg_sel | input | 5 | Register field: tested, link or return register, or trap code |
| reg_val | input | 32 | Value of the register named by `reg_sel` |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | PC that the next edge will load |
| link_val | output | 32 | Return address for a call |
| link_idx | output | 5 | Register to receive `link_val` |
| link_we | output | 1 | Write request for the link register |
| halted | output | 1 | Machine stopped by trap code 0 |

## Verification
A wrong branch decision, a wrong sign extension or a bad increment shows up on `pc` at the first sample after the edge that executes the instruction. No later instruction is needed to expose it. The link outputs are combinational, so a wrong link value or a wrong write request shows in the same cycle as the call. A halt latch that fails to set or to stick shows as `pc` moving during the steps that follow a stop trap. The bench steps the block through random mixes of all eight kinds and several directed corner cases. It compares every PC against a reference model of the sequence.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [2:0] {
      FK_SEQ  = 3'd0,
      FK_JMP  = 3'd1,
      FK_JT   = 3'd2,
      FK_JF   = 3'd3,
      FK_CALL = 3'd4,
      FK_RET  = 3'd5,
      FK_TRAP = 3'd6,
      FK_RSVD = 3'd7
   } flow_kind_e;

   typedef enum logic [1:0] {
      SRC_INC  = 2'd0,
      SRC_TGT  = 2'd1,
      SRC_REG  = 2'd2,
      SRC_HOLD = 2'd3
   } pc_src_e;

   localparam int unsigned STOP_CODE = 0;

endpackage

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN        = 32,
   parameter int AFIELD_W    = 22,
   parameter bit SIGNED_ADDR = 1'b1
) (
   input  logic [AFIELD_W-1:0] addr_field,
   output logic [XLEN-1:0]     target
);
   localparam int PAD_W = XLEN - AFIELD_W;

   initial begin
      if (AFIELD_W < 1 || AFIELD_W >= XLEN)
         $fatal(1, "npc_target: AFIELD_W must lie in 1..XLEN-1");
   end

   generate
      if (SIGNED_ADDR) begin : g_sext
         assign target = {{PAD_W{addr_field[AFIELD_W-1]}}, addr_field};
      end else begin : g_zext
         assign target = {{PAD_W{1'b0}}, addr_field};
      end
   endgenerate
endmodule

// File: rtl/npc_decide.sv
module npc_decide
   import npc_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int RIDX_W = 5
) (
   input  logic              active,
   input  flow_kind_e        kind,
   input  logic [RIDX_W-1:0] reg_sel,
   input  logic [XLEN-1:0]   reg_val,
   output pc_src_e           src,
   output logic              call_req,
   output logic              stop_req
);
   logic reg_nonzero;
   logic code_stop;

   assign reg_nonzero = |reg_val;
   assign code_stop   = (reg_sel == RIDX_W'(STOP_CODE));

   always_comb begin
      src      = SRC_HOLD;
      call_req = 1'b0;
      stop_req = 1'b0;
      if (active) begin
         unique case (kind)
            FK_JMP:  src = SRC_TGT;
            FK_JT:   src = reg_nonzero ? SRC_TGT : SRC_INC;
            FK_JF:   src = reg_nonzero ? SRC_INC : SRC_TGT;
            FK_CALL: begin
               src      = SRC_TGT;
               call_req = 1'b1;
            end
            FK_RET:  src = SRC_REG;
            FK_TRAP: begin
               if (code_stop) begin
                  src      = SRC_HOLD;
                  stop_req = 1'b1;
               end else begin
                  src = SRC_INC;
               end
            end
            default: src = SRC_INC;
         endcase
      end
   end
endmodule

// File: rtl/npc_link.sv
module npc_link #(
   parameter int XLEN         = 32,
   parameter int RIDX_W       = 5,
   parameter bit DROP_ZERO_RD = 1'b1
) (
   input  logic              call_req,
   input  logic [RIDX_W-1:0] reg_sel,
   input  logic [XLEN-1:0]   pc_inc,
   output logic [XLEN-1:0]   link_val,
   output logic [RIDX_W-1:0] link_idx,
   output logic              link_we
);
   assign link_val = pc_inc;
   assign link_idx = reg_sel;

   generate
      if (DROP_ZERO_RD) begin : g_drop_r0
         assign link_we = call_req && (reg_sel != '0);
      end else begin : g_keep_r0
         assign link_we = call_req;
      end
   endgenerate
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int          XLEN        = 32,
   parameter int          AFIELD_W    = 22,
   parameter int          RIDX_W      = 5,
   parameter logic [31:0] RESET_PC    = 32'd0,
   parameter int          PC_STEP     = 1,
   parameter bit          SIGNED_ADDR = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  logic [2:0]          kind,
   input  logic [AFIELD_W-1:0] addr_field,
   input  logic [RIDX_W-1:0]   reg_sel,
   input  logic [XLEN-1:0]     reg_val,
   output logic [XLEN-1:0]     pc,
   output logic [XLEN-1:0]     next_pc,
   output logic [XLEN-1:0]     link_val,
   output logic [RIDX_W-1:0]   link_idx,
   output logic                link_we,
   output logic                halted
);
   localparam logic [XLEN-1:0] INC = XLEN'(PC_STEP);
   localparam logic [XLEN-1:0] RST = XLEN'(RESET_PC);

   initial begin
      if (XLEN < 8 || XLEN > 32) $fatal(1, "npc_unit: XLEN out of range");
      if (PC_STEP < 1)           $fatal(1, "npc_unit: PC_STEP must be positive");
      if (RIDX_W < 1)            $fatal(1, "npc_unit: RIDX_W must be positive");
   end

   logic [XLEN-1:0] pc_q;
   logic            halt_q;
   logic [XLEN-1:0] pc_inc;
   logic [XLEN-1:0] target;
   logic            active;
   pc_src_e         src;
   logic            call_req;
   logic            stop_req;

   assign active = step && !halt_q;
   assign pc_inc = pc_q + INC;

   npc_target #(
      .XLEN(XLEN), .AFIELD_W(AFIELD_W), .SIGNED_ADDR(SIGNED_ADDR)
   ) u_target (
      .addr_field(addr_field),
      .target    (target)
   );

   npc_decide #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_decide (
      .active  (active),
      .kind    (flow_kind_e'(kind)),
      .reg_sel (reg_sel),
      .reg_val (reg_val),
      .src     (src),
      .call_req(call_req),
      .stop_req(stop_req)
   );

   npc_link #(.XLEN(XLEN), .RIDX_W(RIDX_W), .DROP_ZERO_RD(1'b1)) u_link (
      .call_req(call_req),
      .reg_sel (reg_sel),
      .pc_inc  (pc_inc),
      .link_val(link_val),
      .link_idx(link_idx),
      .link_we (link_we)
   );

   always_comb begin
      unique case (src)
         SRC_INC: next_pc = pc_inc;
         SRC_TGT: next_pc = target;
         SRC_REG: next_pc = reg_val;
         default: next_pc = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RST;
         halt_q <= 1'b0;
      end else begin
         pc_q <= next_pc;
         if (stop_req) halt_q <= 1'b1;
      end
   end

   assign pc     = pc_q;
   assign halted = halt_q;

   AST_HALT_FREEZE:  assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc)));                                    // R10
   AST_HALT_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !link_we);                                                   // R10
   AST_IDLE_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
      (!step) |=> $stable(pc));                                               // R11
   AST_SEQ_INC:      assert property (@(posedge clk) disable iff (!rst_n)
      (step && !halted && kind == 3'd0) |=> (pc == $past(pc) + INC));        // R2
   AST_RET_LOAD:     assert property (@(posedge clk) disable iff (!rst_n)
      (step && !halted && kind == 3'd5) |=> (pc == $past(reg_val)));         // R8
   AST_STOP_TRAP:    assert property (@(posedge clk) disable iff (!rst_n)
      (step && !halted && kind == 3'd6 && reg_sel == '0)
         |=> (halted && $stable(pc)));                                        // R9
   AST_CALL_ZERO:    assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (link_idx != '0 && kind == 3'd4));                          // R7
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        step;
   logic [2:0]  kind;
   logic [21:0] addr_field;
   logic [4:0]  reg_sel;
   logic [31:0] reg_val;
   logic [31:0] pc, next_pc, link_val;
   logic [4:0]  link_idx;
   logic        link_we, halted;

   int          checks = 0;
   int          errors = 0;
   logic [31:0] m_pc;
   logic        m_halt;

   always #5 clk = ~clk;

   npc_unit uut (
      .clk(clk), .rst_n(rst_n), .step(step), .kind(kind),
      .addr_field(addr_field), .reg_sel(reg_sel), .reg_val(reg_val),
      .pc(pc), .next_pc(next_pc), .link_val(link_val), .link_idx(link_idx),
      .link_we(link_we), .halted(halted)
   );

   function automatic logic [31:0] sext(input logic [21:0] a);
      return {{10{a[21]}}, a};
   endfunction

   function automatic logic [31:0] model_next(input logic [31:0] p, input logic h,
                                              input logic st, input logic [2:0] k,
                                              input logic [21:0] a, input logic [4:0] rs,
                                              input logic [31:0] rv);
      if (h || !st) return p;
      case (k)
         3'd1, 3'd4: return sext(a);
         3'd2:       return (rv != 0) ? sext(a) : p + 1;
         3'd3:       return (rv == 0) ? sext(a) : p + 1;
         3'd5:       return rv;
         3'd6:       return (rs == 0) ? p : p + 1;
         default:    return p + 1;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] k, input logic [4:0] rs);
      case (k)
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return (rs == 0) ? "R7" : "R6";
         3'd5: return "R8";
         3'd6: return "R9";
         default: return "R2";
      endcase
   endfunction

   // drive after a falling edge, check link outputs, clock, check pc and halt
   task automatic do_op(input logic st, input logic [2:0] k, input logic [21:0] a,
                        input logic [4:0] rs, input logic [31:0] rv);
      logic [31:0] exp_pc;
      logic        exp_we;
      logic        exp_h;
      string       rq;
      rq = m_halt ? "R10" : (!st ? "R11" : req_of(k, rs));
      step = st; kind = k; addr_field = a; reg_sel = rs; reg_val = rv;
      #1;
      exp_we = st && !m_halt && k == 3'd4 && rs != 0;
      chk(link_we === exp_we, rq, 32'(link_we), 32'(exp_we));
      if (exp_we) begin
         chk(link_val === m_pc + 1, "R6", link_val, m_pc + 1);
         chk(link_idx === rs, "R6", 32'(link_idx), 32'(rs));
      end
      exp_pc = model_next(m_pc, m_halt, st, k, a, rs, rv);
      exp_h  = m_halt || (st && k == 3'd6 && rs == 0);
      @(posedge clk);
      @(negedge clk);
      m_pc = exp_pc; m_halt = exp_h;
      chk(pc === m_pc, rq, pc, m_pc);
      chk(halted === m_halt, rq, 32'(halted), 32'(m_halt));
   endtask

   task automatic do_reset();
      rst_n = 1'b0; step = 1'b0; kind = 3'd0; addr_field = '0;
      reg_sel = '0; reg_val = '0;
      @(negedge clk);
      chk(pc === 32'd0, "R1", pc, 32'd0);
      chk(halted === 1'b0, "R1", 32'(halted), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m_pc = 32'd0; m_halt = 1'b0;
      #1;
      chk(pc === 32'd0 && halted === 1'b0 && link_we === 1'b0, "R1", pc, 32'd0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      do_reset();
      // directed corners
      do_op(1, 3'd0, 22'h0, 5'd0, 32'd0);                // R2
      do_op(1, 3'd7, 22'h0, 5'd0, 32'd0);                // R2 reserved
      do_op(1, 3'd1, 22'h200000, 5'd0, 32'd0);           // R3 negative target
      do_op(1, 3'd1, 22'h1FFFFF, 5'd0, 32'd0);           // R3 largest positive
      do_op(1, 3'd2, 22'h000040, 5'd3, 32'd0);           // R4 not taken
      do_op(1, 3'd2, 22'h000040, 5'd3, 32'h8000_0000);   // R4 taken
      do_op(1, 3'd3, 22'h000080, 5'd3, 32'd1);           // R5 not taken
      do_op(1, 3'd3, 22'h000080, 5'd3, 32'd0);           // R5 taken
      do_op(1, 3'd4, 22'h000100, 5'd31, 32'd0);          // R6
      do_op(1, 3'd4, 22'h000200, 5'd0, 32'd0);           // R7
      do_op(1, 3'd5, 22'h0, 5'd31, 32'hDEAD_BEEF);       // R8
      do_op(0, 3'd1, 22'h3, 5'd0, 32'd0);                // R11
      do_op(0, 3'd4, 22'h3, 5'd9, 32'd0);                // R11
      do_op(1, 3'd6, 22'h0, 5'd1, 32'd0);                // R9 non-stop code
      do_op(1, 3'd6, 22'h0, 5'd0, 32'd0);                // R9 stop
      do_op(1, 3'd1, 22'h5, 5'd0, 32'd0);                // R10
      do_op(1, 3'd4, 22'h5, 5'd7, 32'd0);                // R10 no link
      do_op(1, 3'd5, 22'h0, 5'd2, 32'h1234);             // R10
      do_reset();
      // constrained random
      for (int i = 0; i < 1500; i++) begin
         logic [2:0]  k;
         logic [4:0]  rs;
         logic [31:0] rv;
         k  = 3'($urandom_range(0, 7));
         rs = (k == 3'd6) ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
         rv = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom;
         do_op($urandom_range(0, 9) != 0, k, 22'($urandom), rs, rv);
         if (m_halt && $urandom_range(0, 3) == 0) do_reset();
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule